// File: doc/BRIEF.md
# Translation Buffer with Virtually Indexed, Physically Tagged Cache Lookup

This block turns a virtual load or store address into a physical one. In the same cycle it decides whether the addressed line is present in a set-associative L1 cache. A small fully associative translation buffer holds recently used mappings from virtual page number to physical page number. While that buffer searches, the cache set is already being selected with virtual address bits that sit inside the 8 KB page offset. Those bits are identical in the virtual and the physical address. The physical page number found by the buffer is then compared against the physical tags stored in every way of that set. One registered cycle after the request, the block reports translation hit, cache hit, the hitting way and the physical address.

When the translation is missing, the block raises a miss pulse that carries the virtual page number. An external page walker answers on the fill port. The fill goes to an existing entry with the same page number if one exists, else to the lowest-numbered invalid entry, else to the least recently used entry. The requester then repeats the access. A flush input invalidates every translation. Tags reach the cache through a separate tag install port, which is the hook that the line refill logic outside this block uses.

Because tags are physical, two virtual pages that map to the same physical page find the same cache line. This holds as long as their low 13 address bits agree.

Top module: `tlb_vipt_lookup`

## Requirements
- R1: The low 13 bits of `rsp_pa` equal the low 13 bits of the request address. The upper bits of `rsp_pa` hold the translated physical page number.
- R2: A request that finds a valid entry with a matching virtual page number (address bits 31:13) returns `rsp_valid`=1, `rsp_tlb_hit`=1 and that entry's physical page number. The response arrives on the clock edge after the request.
- R3: A request that finds no matching valid entry returns `rsp_tlb_hit`=0, `rsp_cache_hit`=0 and `rsp_pa`=0. It also returns `miss_valid`=1 with `miss_vpn` set to the request's page number.
- R4: A fill whose page number is already held overwrites that entry, and no other entry changes. Otherwise the fill takes the lowest-numbered invalid entry, or the least recently used entry when all 16 entries are valid.
- R5: A lookup hit and a fill both make the touched entry the most recently used one. The entry chosen for eviction is the one touched longest ago.
- R6: A pulse on `flush` clears every translation, and later lookups miss until new fills arrive. A fill in the same cycle as the flush is dropped. Cache tags are not affected by the flush.
- R7: The cache set is taken from address bits 10:5, which lie inside the page offset. A cache hit is reported when any way of that set holds a valid tag equal to the translated page number. `rsp_way` gives the lowest hitting way. Two virtual pages that map to one physical page hit the same way.
- R8: `rsp_cache_hit` is 1 only together with `rsp_tlb_hit`, even if a stored tag equals the value present on a missing lookup.
- R9: After reset, every response output is 0, every translation is invalid and every cache tag is invalid.
- R10: When a fill and a lookup of the same page number occur in one cycle, the lookup sees the contents from before the fill and misses. The next lookup of that page number hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address of the request |
| flush | input | 1 | Invalidate all translations |
| fill_valid | input | 1 | Translation fill strobe |
| fill_vpn | input | 19 | Virtual page number being filled |
| fill_ppn | input | 17 | Physical page number being filled |
| tag_wr_en | input | 1 | Install a physical tag into the cache tag array |
| tag_wr_way | input | 1 | Way to install into |
| tag_wr_set | input | 6 | Set to install into |
| tag_wr_ppn | input | 17 | Physical page number stored as the tag |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_tlb_hit | output | 1 | Translation found |
| rsp_cache_hit | output | 1 | Physical tag matched in the selected set |
| rsp_way | output | 1 | Hitting way |
| rsp_pa | output | 30 | Physical address, 0 on a translation miss |
| miss_valid | output | 1 | Translation miss request to the page walker |
| miss_vpn | output | 19 | Page number that missed |

## Verification
The bench fills all 16 entries, touches the oldest one and then fills again. A replacement policy that evicted by age of insertion, or that ignored lookup touches, would throw out the wrong page, and the bench sees this as a wrong miss or a wrong hit. It refills a page number that is already present and then checks that all other entries still hit. A design that skipped the duplicate check would evict a live entry or keep two copies of one page. It maps two virtual pages to one physical page and expects the same way to hit for both, which a design that compared virtual tags would fail. It also installs a tag of value zero and looks up an untranslated page, so a cache hit that did not wait for the translation hit shows up as a false hit. Finally, it issues a fill and a lookup of the same page in one cycle, which exposes a design that forwarded the new entry into the lookup.

// File: rtl/tlbv_pkg.sv
package tlbv_pkg;
  // translated boundary: bits below this are never changed
  localparam int PAGE_BITS = 13;

  // where a translation fill lands
  typedef enum logic [1:0] {
    SLOT_SAME = 2'd0,  // page already held, overwrite in place
    SLOT_FREE = 2'd1,  // lowest invalid entry
    SLOT_OLD  = 2'd2   // least recently used entry
  } slot_src_e;
endpackage

// File: rtl/tlbv_lru.sv
// Recency ranks: each entry owns a distinct age, 0 = most recent,
// N-1 = next victim. A touch moves one entry to age 0 and ages
// everything that was younger than it by one.
module tlbv_lru #(
  parameter int N = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 touch_en,
  input  logic [$clog2(N)-1:0] touch_idx,
  output logic [$clog2(N)-1:0] victim_idx
);
  localparam int AW = $clog2(N);

  logic [AW-1:0] age_q [N];
  logic [AW-1:0] age_d [N];
  logic [AW-1:0] touched_age;

  always_comb begin
    touched_age = age_q[touch_idx];
    for (int i = 0; i < N; i++) begin
      age_d[i] = age_q[i];
      if (touch_en) begin
        if (AW'(i) == touch_idx) begin
          age_d[i] = '0;
        end else if (age_q[i] < touched_age) begin
          age_d[i] = age_q[i] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (age_q[i] == AW'(N - 1)) victim_idx = AW'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= AW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) age_q[i] <= age_d[i];
    end
  end
endmodule

// File: rtl/tlbv_cam.sv
// Fully associative translation store with fill slot selection.
module tlbv_cam
  import tlbv_pkg::*;
#(
  parameter int N     = 16,
  parameter int VPN_W = 19,
  parameter int PPN_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             look_en,
  input  logic [VPN_W-1:0] look_vpn,
  input  logic             flush,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  output logic [N-1:0]     match_vec,
  output logic [N-1:0]     valid_vec,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn
);
  localparam int IW = $clog2(N);

  logic [N-1:0]     vld_q, vld_d;
  logic [VPN_W-1:0] vpn_q [N];
  logic [PPN_W-1:0] ppn_q [N];

  logic [IW-1:0] hit_idx, same_idx, free_idx, victim_idx, fill_idx;
  logic          same_any, free_any, fill_go, touch_en;
  logic [IW-1:0] touch_idx;
  slot_src_e     slot_src;

  // parallel compare of every entry
  always_comb begin
    hit_ppn = '0;
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      match_vec[i] = vld_q[i] && (vpn_q[i] == look_vpn);
      if (match_vec[i]) begin
        hit_ppn = hit_ppn | ppn_q[i];
        hit_idx = IW'(i);
      end
    end
    hit = |match_vec;
  end

  // fill slot: same page first, then lowest invalid, then oldest
  always_comb begin
    same_any = 1'b0;
    same_idx = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vld_q[i] && (vpn_q[i] == fill_vpn)) begin
        same_any = 1'b1;
        same_idx = IW'(i);
      end
      if (!vld_q[i]) begin
        free_any = 1'b1;
        free_idx = IW'(i);
      end
    end
    if (same_any)      slot_src = SLOT_SAME;
    else if (free_any) slot_src = SLOT_FREE;
    else               slot_src = SLOT_OLD;
    case (slot_src)
      SLOT_SAME: fill_idx = same_idx;
      SLOT_FREE: fill_idx = free_idx;
      default:   fill_idx = victim_idx;
    endcase
  end

  always_comb begin
    fill_go   = fill_valid && !flush;
    touch_en  = fill_go || (look_en && hit);
    touch_idx = fill_go ? fill_idx : hit_idx;
    vld_d     = vld_q;
    if (flush) begin
      vld_d = '0;
    end else if (fill_go) begin
      vld_d[fill_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      vpn_q[fill_idx] <= fill_vpn;
      ppn_q[fill_idx] <= fill_ppn;
    end
  end

  tlbv_lru #(.N(N)) i_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (touch_en),
    .touch_idx  (touch_idx),
    .victim_idx (victim_idx)
  );

  assign valid_vec = vld_q;
endmodule

// File: rtl/tlbv_tags.sv
// Physical tag store, read by set and compared against a page number.
module tlbv_tags #(
  parameter int WAYS  = 2,
  parameter int SETS  = 64,
  parameter int PPN_W = 17,
  parameter int WAY_W = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [WAY_W-1:0]        wr_way,
  input  logic [$clog2(SETS)-1:0] wr_set,
  input  logic [PPN_W-1:0]        wr_ppn,
  input  logic [$clog2(SETS)-1:0] rd_set,
  input  logic [PPN_W-1:0]        cmp_ppn,
  output logic [WAYS-1:0]         way_hit
);
  logic [PPN_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic wr_here;
    assign wr_here    = wr_en && (wr_way == WAY_W'(w));
    assign way_hit[w] = vld_q[rd_set][w] && (tag_q[rd_set][w] == cmp_ppn);

    always_ff @(posedge clk) begin
      if (wr_here) tag_q[wr_set][w] <= wr_ppn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (wr_en) begin
      vld_q[wr_set][wr_way] <= 1'b1;
    end
  end
endmodule

// File: rtl/tlb_vipt_lookup.sv
module tlb_vipt_lookup
  import tlbv_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 30,
  parameter int ENTRIES    = 16,
  parameter int WAYS       = 2,
  parameter int SETS       = 64,
  parameter int LINE_BYTES = 32,
  localparam int VPN_W = VA_W - PAGE_BITS,
  localparam int PPN_W = PA_W - PAGE_BITS,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic             flush,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             tag_wr_en,
  input  logic [WAY_W-1:0] tag_wr_way,
  input  logic [IDX_W-1:0] tag_wr_set,
  input  logic [PPN_W-1:0] tag_wr_ppn,
  output logic             rsp_valid,
  output logic             rsp_tlb_hit,
  output logic             rsp_cache_hit,
  output logic [WAY_W-1:0] rsp_way,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             miss_valid,
  output logic [VPN_W-1:0] miss_vpn
);
  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [VPN_W-1:0]  look_vpn;
  logic [IDX_W-1:0]  look_set;
  logic [ENTRIES-1:0] tlb_match, tlb_valid;
  logic              tlb_hit;
  logic [PPN_W-1:0]  tlb_ppn;
  logic [WAYS-1:0]   way_hit;

  // set select uses only bits below the page boundary
  assign look_vpn = req_va[VA_W-1:PAGE_BITS];
  assign look_set = req_va[OFF_W+IDX_W-1:OFF_W];

  tlbv_cam #(.N(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) i_cam (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .look_en    (req_valid),
    .look_vpn   (look_vpn),
    .flush      (flush),
    .fill_valid (fill_valid),
    .fill_vpn   (fill_vpn),
    .fill_ppn   (fill_ppn),
    .match_vec  (tlb_match),
    .valid_vec  (tlb_valid),
    .hit        (tlb_hit),
    .hit_ppn    (tlb_ppn)
  );

  tlbv_tags #(.WAYS(WAYS), .SETS(SETS), .PPN_W(PPN_W), .WAY_W(WAY_W)) i_tags (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (tag_wr_en),
    .wr_way  (tag_wr_way),
    .wr_set  (tag_wr_set),
    .wr_ppn  (tag_wr_ppn),
    .rd_set  (look_set),
    .cmp_ppn (tlb_ppn),
    .way_hit (way_hit)
  );

  logic             valid_d, thit_d, chit_d, miss_d;
  logic [WAY_W-1:0] way_d;
  logic [PA_W-1:0]  pa_d;
  logic [VPN_W-1:0] mvpn_d;

  always_comb begin
    valid_d = req_valid;
    thit_d  = req_valid && tlb_hit;
    chit_d  = thit_d && (|way_hit);
    miss_d  = req_valid && !tlb_hit;
    way_d   = '0;
    if (chit_d) begin
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (way_hit[w]) way_d = WAY_W'(w);
      end
    end
    pa_d   = thit_d ? {tlb_ppn, req_va[PAGE_BITS-1:0]} : '0;
    mvpn_d = miss_d ? look_vpn : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid     <= 1'b0;
      rsp_tlb_hit   <= 1'b0;
      rsp_cache_hit <= 1'b0;
      rsp_way       <= '0;
      rsp_pa        <= '0;
      miss_valid    <= 1'b0;
      miss_vpn      <= '0;
    end else begin
      rsp_valid     <= valid_d;
      rsp_tlb_hit   <= thit_d;
      rsp_cache_hit <= chit_d;
      rsp_way       <= way_d;
      rsp_pa        <= pa_d;
      miss_valid    <= miss_d;
      miss_vpn      <= mvpn_d;
    end
  end
endmodule

// File: rtl/tlb_vipt_chk.sv
module tlb_vipt_chk #(
  parameter int ENTRIES = 16,
  parameter int OFFB    = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [OFFB-1:0]    req_off,
  input logic               flush,
  input logic               fill_valid,
  input logic               rsp_valid,
  input logic               rsp_tlb_hit,
  input logic               rsp_cache_hit,
  input logic [OFFB-1:0]    rsp_off,
  input logic               miss_valid,
  input logic [ENTRIES-1:0] tlb_match,
  input logic [ENTRIES-1:0] tlb_valid
);
  // R1
  pa_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_tlb_hit) |-> (rsp_off == $past(req_off)));

  // R2
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));

  // R3
  miss_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> (rsp_valid && !rsp_tlb_hit && !rsp_cache_hit));

  // R4
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tlb_match));

  // R4
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fill_valid && !flush) |-> (tlb_valid != '0));

  // R6
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> (tlb_valid == '0));

  // R8
  cache_after_tlb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_cache_hit |-> rsp_tlb_hit);
endmodule

bind tlb_vipt_lookup tlb_vipt_chk #(.ENTRIES(ENTRIES), .OFFB(tlbv_pkg::PAGE_BITS)) i_chk (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .req_valid     (req_valid),
  .req_off       (req_va[tlbv_pkg::PAGE_BITS-1:0]),
  .flush         (flush),
  .fill_valid    (fill_valid),
  .rsp_valid     (rsp_valid),
  .rsp_tlb_hit   (rsp_tlb_hit),
  .rsp_cache_hit (rsp_cache_hit),
  .rsp_off       (rsp_pa[tlbv_pkg::PAGE_BITS-1:0]),
  .miss_valid    (miss_valid),
  .tlb_match     (tlb_match),
  .tlb_valid     (tlb_valid)
);

// File: tb/test_tlb_vipt_lookup.sv
`timescale 1ns/1ps
module test_tlb_vipt_lookup;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_va;
  logic        flush;
  logic        fill_valid;
  logic [18:0] fill_vpn;
  logic [16:0] fill_ppn;
  logic        tag_wr_en;
  logic [0:0]  tag_wr_way;
  logic [5:0]  tag_wr_set;
  logic [16:0] tag_wr_ppn;
  logic        rsp_valid, rsp_tlb_hit, rsp_cache_hit, miss_valid;
  logic [0:0]  rsp_way;
  logic [29:0] rsp_pa;
  logic [18:0] miss_vpn;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  tlb_vipt_lookup i_tlb_vipt_lookup (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .flush(flush), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .tag_wr_en(tag_wr_en), .tag_wr_way(tag_wr_way),
    .tag_wr_set(tag_wr_set), .tag_wr_ppn(tag_wr_ppn), .rsp_valid(rsp_valid),
    .rsp_tlb_hit(rsp_tlb_hit), .rsp_cache_hit(rsp_cache_hit),
    .rsp_way(rsp_way), .rsp_pa(rsp_pa), .miss_valid(miss_valid),
    .miss_vpn(miss_vpn)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // vector layout: op[49:48] vpn[47:29] hi[28:27] set[26:21] ppn[20:4]
  //                way[3] exp_tlb[2] exp_cache[1] exp_way[0]
  // op 0 = lookup, 1 = fill, 2 = tag install
  localparam int NVEC = 13;
  localparam logic [49:0] VEC [NVEC] = '{
    {2'd0, 19'h00010, 2'd0, 6'd3, 17'h00000, 1'b0, 3'b000},
    {2'd1, 19'h00010, 2'd0, 6'd0, 17'h000aa, 1'b0, 3'b000},
    {2'd0, 19'h00010, 2'd0, 6'd3, 17'h000aa, 1'b0, 3'b100},
    {2'd2, 19'h00000, 2'd0, 6'd3, 17'h000aa, 1'b1, 3'b000},
    {2'd0, 19'h00010, 2'd0, 6'd3, 17'h000aa, 1'b0, 3'b111},
    {2'd0, 19'h00010, 2'd1, 6'd4, 17'h000aa, 1'b0, 3'b100},
    {2'd1, 19'h00022, 2'd0, 6'd0, 17'h000aa, 1'b0, 3'b000},
    {2'd0, 19'h00022, 2'd0, 6'd3, 17'h000aa, 1'b0, 3'b111},
    {2'd2, 19'h00000, 2'd0, 6'd4, 17'h000bb, 1'b0, 3'b000},
    {2'd0, 19'h00010, 2'd3, 6'd4, 17'h000aa, 1'b0, 3'b100},
    {2'd1, 19'h00033, 2'd0, 6'd0, 17'h000bb, 1'b0, 3'b000},
    {2'd0, 19'h00033, 2'd2, 6'd4, 17'h000bb, 1'b0, 3'b110},
    {2'd0, 19'h00044, 2'd0, 6'd4, 17'h00000, 1'b0, 3'b000}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkva(input logic [18:0] vpn, input logic [1:0] hi,
                                       input logic [5:0] set);
    logic [4:0] off;
    off = 5'(set + 6'd7);
    return {vpn, hi, set, off};
  endfunction

  task automatic do_fill(input logic [18:0] vpn, input logic [16:0] ppn);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_tag(input logic way, input logic [5:0] set, input logic [16:0] ppn);
    tag_wr_en = 1'b1; tag_wr_way = way; tag_wr_set = set; tag_wr_ppn = ppn;
    @(negedge clk);
    tag_wr_en = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  // one lookup; response sampled at the negedge after the capturing edge
  task automatic do_look(input string what, input logic [18:0] vpn, input logic [1:0] hi,
                         input logic [5:0] set, input logic exp_tlb, input logic exp_cache,
                         input logic exp_way, input logic [16:0] exp_ppn);
    logic [31:0] va;
    va = mkva(vpn, hi, set);
    req_valid = 1'b1; req_va = va;
    @(negedge clk);
    req_valid = 1'b0;
    chk({what, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({what, " tlb_hit"}, 32'(rsp_tlb_hit), 32'(exp_tlb));
    chk({what, " cache_hit"}, 32'(rsp_cache_hit), 32'(exp_cache));
    if (exp_cache) chk({what, " way"}, 32'(rsp_way), 32'(exp_way));
    if (exp_tlb) begin
      chk({what, " pa R1"}, 32'(rsp_pa), 32'({exp_ppn, va[12:0]}));
      chk({what, " no miss"}, 32'(miss_valid), 32'd0);
    end else begin
      chk({what, " pa zero R3"}, 32'(rsp_pa), 32'd0);
      chk({what, " miss R3"}, 32'(miss_valid), 32'd1);
      chk({what, " miss_vpn R3"}, 32'(miss_vpn), 32'(vpn));
    end
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_va = '0; flush = 1'b0;
    fill_valid = 1'b0; fill_vpn = '0; fill_ppn = '0;
    tag_wr_en = 1'b0; tag_wr_way = '0; tag_wr_set = '0; tag_wr_ppn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: reset state of all response outputs
    chk("R9 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R9 tlb_hit", 32'(rsp_tlb_hit), 32'd0);
    chk("R9 cache_hit", 32'(rsp_cache_hit), 32'd0);
    chk("R9 miss_valid", 32'(miss_valid), 32'd0);
    chk("R9 pa", 32'(rsp_pa), 32'd0);

    // table walk: R2 R3 R7, with R9 seen as empty TLB and empty tags
    for (int k = 0; k < NVEC; k++) begin
      logic [49:0] v;
      v = VEC[k];
      case (v[49:48])
        2'd1: do_fill(v[47:29], v[20:4]);
        2'd2: do_tag(v[3], v[26:21], v[20:4]);
        default: do_look($sformatf("R2/R3/R7 vector %0d", k), v[47:29], v[28:27],
                         v[26:21], v[2], v[1], v[0], v[20:4]);
      endcase
    end

    // R8: zero tag present, translation missing
    do_tag(1'b0, 6'd9, 17'h00000);
    do_look("R8 untranslated vs zero tag", 19'h00055, 2'd0, 6'd9, 1'b0, 1'b0, 1'b0, 17'h0);

    // R6: flush removes translations but keeps tags
    do_flush();
    do_look("R6 after flush", 19'h00010, 2'd0, 6'd3, 1'b0, 1'b0, 1'b0, 17'h0);
    do_look("R6 alias after flush", 19'h00022, 2'd0, 6'd3, 1'b0, 1'b0, 1'b0, 17'h0);
    do_fill(19'h00010, 17'h000aa);
    do_look("R6 tags kept", 19'h00010, 2'd0, 6'd3, 1'b1, 1'b1, 1'b1, 17'h000aa);

    // R4 R5: fill all entries, touch the oldest, then replace
    do_flush();
    for (int i = 0; i < 16; i++) do_fill(19'h00100 + 19'(i), 17'h01000 + 17'(i));
    do_look("R5 touch oldest", 19'h00100, 2'd0, 6'd1, 1'b1, 1'b0, 1'b0, 17'h01000);
    do_fill(19'h00200, 17'h01200);
    do_look("R5 evicted second oldest", 19'h00101, 2'd0, 6'd1, 1'b0, 1'b0, 1'b0, 17'h0);
    do_look("R5 touched entry kept", 19'h00100, 2'd0, 6'd1, 1'b1, 1'b0, 1'b0, 17'h01000);
    do_look("R4 new entry", 19'h00200, 2'd0, 6'd1, 1'b1, 1'b0, 1'b0, 17'h01200);

    // R4: refill of a held page overwrites in place, nothing evicted
    do_fill(19'h00105, 17'h01555);
    do_look("R4 refilled page", 19'h00105, 2'd0, 6'd2, 1'b1, 1'b0, 1'b0, 17'h01555);
    for (int i = 0; i < 16; i++) begin
      if (i != 1 && i != 5)
        do_look($sformatf("R4 entry %0d survives", i), 19'h00100 + 19'(i), 2'd0, 6'd2,
                1'b1, 1'b0, 1'b0, 17'h01000 + 17'(i));
    end
    do_look("R4 new entry survives", 19'h00200, 2'd0, 6'd2, 1'b1, 1'b0, 1'b0, 17'h01200);

    // R10: fill and lookup of one page in the same cycle
    fill_valid = 1'b1; fill_vpn = 19'h00300; fill_ppn = 17'h01300;
    do_look("R10 same-cycle lookup", 19'h00300, 2'd0, 6'd5, 1'b0, 1'b0, 1'b0, 17'h0);
    fill_valid = 1'b0;
    do_look("R10 next lookup", 19'h00300, 2'd0, 6'd5, 1'b1, 1'b0, 1'b0, 17'h01300);

    // R2: idle cycle gives no response
    @(negedge clk);
    chk("R2 idle rsp_valid", 32'(rsp_valid), 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule